// File: doc/BRIEF.md
# Replicated Block-Cipher Array Slave

This block is a memory-mapped slave that holds a parameterised number of 64-bit Feistel cipher engines (1 to 16 replicas) behind a single 32-bit register port. Software loads one shared 128-bit key and, replica by replica, a 64-bit input block as two 32-bit words. A single control write then fires every replica on the same clock. Each replica runs 32 rounds of the extended tiny cipher (delta 0x9E3779B9, shifts of 4 left and 5 right, additions modulo 2^32) in encrypt or decrypt direction. Software polls one status word and then reads each replica's 64-bit result.

A run controller steps through four named states. `C_IDLE` is the state after reset. `C_FIRE` lasts one cycle and drives the start pulse to all engines. `C_WAIT` collects the done flags, and `C_FINISHED` holds completion until the next start. The transitions are: IDLE->FIRE and FINISHED->FIRE on an accepted start write, FIRE->WAIT always, and WAIT->FINISHED when every replica has reported done. Each engine steps through `ST_IDLE`, then `ST_HALF_A`, `ST_SUM`, `ST_HALF_B` and `ST_ROUND_END` once per round, so one run takes 4 x 32 = 128 cycles. The engine returns from `ST_ROUND_END` to `ST_HALF_A` until the last round, and then to `ST_IDLE` while it latches its result.

The register map uses word offsets. Offset 0 is control: bit 0 is start and bit 1 is decrypt. Offset 1 is status: bit 0 is busy and bit 1 is all-done. Offsets 2 to 5 hold key words 0 to 3. For replica i, offset 6+4i holds the first input half and 7+4i the second input half. Offset 8+4i returns the first result half and 9+4i the second result half.

Top module: `cipher_array_slave`

## Requirements
- R1: After reset, every mapped register reads 0: control, status, key, input and result words.
- R2: Writes to key offsets 2..5 and to a replica's input offsets 6+4i and 7+4i are stored, and read back unchanged in the same cycle as the read strobe.
- R3: Writes to status (offset 1) and to result offsets (8+4i, 9+4i) have no effect, and reads of offsets above 5+4N return 0.
- R4: A control write with bit 0 set starts all replicas together with one single-cycle pulse. Control reads return bit 0 as 0 and bit 1 as the stored decrypt mode.
- R5: Status bit 0 (busy) is 1 from the clock edge that takes the start write until all replicas finish. Status bit 1 (all-done) becomes 1, and busy 0, exactly 131 cycles after that edge. All-done clears on the next accepted start.
- R6: With bit 1 = 0, each replica's result is the 32-round encryption of its input pair (first half v0, second half v1). The key word is selected by sum bits [1:0] for the v0 update and by sum bits [12:11] for the v1 update, and sum starts at 0.
- R7: With bit 1 = 1, each replica's result is the 32-round decryption, with sum starting at 0xC6EF3720. Decrypting an encrypted block returns the original block.
- R8: Each replica computes on its own input pair, so different inputs in different replicas give per-replica results.
- R9: A control write while busy is ignored. It changes neither the mode nor the completion time.
- R10: Result words stay unchanged after a run, even when key or input registers are rewritten, until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |

## Verification
Register writes take effect at the clock edge that samples them, and reads return data in the same cycle as the strobe, so the bench samples a read one time unit after the falling edge on which it drives the strobe. After a start write taken at edge W, the engines load at W+1 and raise done at W+129. The collector records the flags at W+130 and the controller enters C_FINISHED at W+131. The bench keeps its own edge counter and reads status at the falling edges after W+130 (busy expected) and after W+131 (all-done expected). Results are compared against bench reference functions only after all-done is observed.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int          WORD_W    = 32;
    localparam logic [31:0] DELTA     = 32'h9E37_79B9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF_A,
        ST_SUM,
        ST_HALF_B,
        ST_ROUND_END
    } eng_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_FIRE,
        C_WAIT,
        C_FINISHED
    } ctl_state_t;

    function automatic word_t mix_f(input word_t x);
        return ((x << 4) ^ (x >> 5)) + x;
    endfunction
endpackage

// File: rtl/cas_round_engine.sv
module cas_round_engine
    import cas_pkg::*;
#(
    parameter int ROUNDS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             decrypt_i,
    input  logic [3:0][31:0] key_i,
    input  word_t            v0_i,
    input  word_t            v1_i,
    output word_t            res0_o,
    output word_t            res1_o,
    output logic             done_o
);
    localparam int          RND_W   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [31:0] SUM_TOP = DELTA * ROUNDS;

    eng_state_t        state_q, state_d;
    logic [RND_W-1:0]  rnd_q;
    word_t             v0_q, v1_q, sum_q;
    logic              dec_q;
    logic              last_rnd;

    assign last_rnd = (rnd_q == RND_W'(ROUNDS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_HALF_A;
            ST_HALF_A:    state_d = ST_SUM;
            ST_SUM:       state_d = ST_HALF_B;
            ST_HALF_B:    state_d = ST_ROUND_END;
            ST_ROUND_END: state_d = last_rnd ? ST_IDLE : ST_HALF_A;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v0_q   <= '0;
            v1_q   <= '0;
            sum_q  <= '0;
            rnd_q  <= '0;
            dec_q  <= 1'b0;
            res0_o <= '0;
            res1_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        v0_q  <= v0_i;
                        v1_q  <= v1_i;
                        dec_q <= decrypt_i;
                        sum_q <= decrypt_i ? SUM_TOP : '0;
                        rnd_q <= '0;
                    end
                end
                ST_HALF_A: begin
                    if (!dec_q) v0_q <= v0_q + (mix_f(v1_q) ^ (sum_q + key_i[sum_q[1:0]]));
                    else        v1_q <= v1_q - (mix_f(v0_q) ^ (sum_q + key_i[sum_q[12:11]]));
                end
                ST_SUM: begin
                    sum_q <= dec_q ? (sum_q - DELTA) : (sum_q + DELTA);
                end
                ST_HALF_B: begin
                    if (!dec_q) v1_q <= v1_q + (mix_f(v0_q) ^ (sum_q + key_i[sum_q[12:11]]));
                    else        v0_q <= v0_q - (mix_f(v1_q) ^ (sum_q + key_i[sum_q[1:0]]));
                end
                ST_ROUND_END: begin
                    if (last_rnd) begin
                        res0_o <= v0_q;
                        res1_o <= v1_q;
                        done_o <= 1'b1;
                    end else begin
                        rnd_q <= rnd_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: a start pulse only ever reaches an idle engine
    a_r9_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == ST_IDLE));

    // R10: results change only together with the done pulse
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(res0_o) && $stable(res1_o)) |-> done_o);

    // R4: done is a single-cycle pulse
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/cas_run_ctrl.sv
module cas_run_ctrl
    import cas_pkg::*;
#(
    parameter int REPLICAS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req_i,
    input  logic [REPLICAS-1:0] done_i,
    output logic                fire_o,
    output logic                busy_o,
    output logic                all_done_o
);
    ctl_state_t          state_q, state_d;
    logic [REPLICAS-1:0] seen_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:     if (start_req_i) state_d = C_FIRE;
            C_FIRE:     state_d = C_WAIT;
            C_WAIT:     if (&seen_q) state_d = C_FINISHED;
            C_FINISHED: if (start_req_i) state_d = C_FIRE;
            default:    state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 seen_q <= '0;
        else if (state_q == C_FIRE) seen_q <= '0;
        else                        seen_q <= seen_q | done_i;
    end

    always_comb begin
        fire_o     = (state_q == C_FIRE);
        busy_o     = (state_q == C_FIRE) || (state_q == C_WAIT);
        all_done_o = (state_q == C_FINISHED);
    end

    // R4: the shared start is one cycle wide
    a_r4_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R5: completion is only reached from a busy run
    a_r5_finish_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_done_o) |-> $past(busy_o));

    // R5: busy and all-done never overlap
    a_r5_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && all_done_o));
endmodule

// File: rtl/cipher_array_slave.sv
module cipher_array_slave
    import cas_pkg::*;
#(
    parameter int REPLICAS = 4,
    parameter int ADDR_W   = 8,
    parameter int ROUNDS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o
);
    localparam int OFF_CTRL    = 0;
    localparam int OFF_STAT    = 1;
    localparam int OFF_KEY     = 2;
    localparam int KEY_WORDS   = 4;
    localparam int OFF_LANE    = OFF_KEY + KEY_WORDS;
    localparam int LANE_STRIDE = 4;

    logic                 mode_q;
    logic [3:0][31:0]     key_q;
    word_t                in0_q  [REPLICAS];
    word_t                in1_q  [REPLICAS];
    word_t                res0_w [REPLICAS];
    word_t                res1_w [REPLICAS];
    logic [REPLICAS-1:0]  done_w;
    logic                 wr_en, ctrl_wr, start_req;
    logic                 fire, busy, all_done;

    assign wr_en     = cs_i && wr_i;
    assign ctrl_wr   = wr_en && (addr_i == ADDR_W'(OFF_CTRL));
    assign start_req = ctrl_wr && wdata_i[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            key_q  <= '0;
            for (int i = 0; i < REPLICAS; i++) begin
                in0_q[i] <= '0;
                in1_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (ctrl_wr && !busy) mode_q <= wdata_i[1];
            for (int k = 0; k < KEY_WORDS; k++) begin
                if (addr_i == ADDR_W'(OFF_KEY + k)) key_q[k] <= wdata_i;
            end
            for (int i = 0; i < REPLICAS; i++) begin
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i))     in0_q[i] <= wdata_i;
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i + 1)) in1_q[i] <= wdata_i;
            end
        end
    end

    cas_run_ctrl #(.REPLICAS(REPLICAS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .done_i      (done_w),
        .fire_o      (fire),
        .busy_o      (busy),
        .all_done_o  (all_done)
    );

    for (genvar g = 0; g < REPLICAS; g++) begin : g_lane
        cas_round_engine #(.ROUNDS(ROUNDS)) u_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (fire),
            .decrypt_i (mode_q),
            .key_i     (key_q),
            .v0_i      (in0_q[g]),
            .v1_i      (in1_q[g]),
            .res0_o    (res0_w[g]),
            .res1_o    (res1_w[g]),
            .done_o    (done_w[g])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (cs_i && rd_i) begin
            if (addr_i == ADDR_W'(OFF_CTRL)) rdata_o = {30'b0, mode_q, 1'b0};
            if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = {30'b0, all_done, busy};
            for (int k = 0; k < KEY_WORDS; k++) begin
                if (addr_i == ADDR_W'(OFF_KEY + k)) rdata_o = key_q[k];
            end
            for (int i = 0; i < REPLICAS; i++) begin
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i))     rdata_o = in0_q[i];
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i + 1)) rdata_o = in1_q[i];
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i + 2)) rdata_o = res0_w[i];
                if (addr_i == ADDR_W'(OFF_LANE + LANE_STRIDE*i + 3)) rdata_o = res1_w[i];
            end
        end
    end

    // R4: the engine start follows an accepted start write by one cycle
    a_r4_fire_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(start_req));

    // R5: all replicas finish in the same cycle
    a_r5_done_together: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_w) |-> (&done_w));

    // R9: the mode does not move during a run
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: tb/cipher_array_slave_tb_top.sv
module cipher_array_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREP       = 4;
    localparam int AW         = 8;
    localparam logic [31:0] DLT = 32'h9E37_79B9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  cyc      = 0;
    int  w_edge   = 0;
    bit  ended    = 1'b0;

    logic [3:0][31:0] key;
    logic [31:0] blk0 [NREP];
    logic [31:0] blk1 [NREP];
    logic [63:0] expv [NREP];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cipher_array_slave #(.REPLICAS(NREP), .ADDR_W(AW), .ROUNDS(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    function automatic logic [31:0] mixb(input logic [31:0] x);
        return ((x << 4) ^ (x >> 5)) + x;
    endfunction

    function automatic logic [63:0] ref_run(input logic [3:0][31:0] k,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input bit dec);
        logic [31:0] s;
        s = dec ? (DLT * 32) : 32'h0;
        for (int r = 0; r < 32; r++) begin
            if (!dec) begin
                a = a + (mixb(b) ^ (s + k[s[1:0]]));
                s = s + DLT;
                b = b + (mixb(a) ^ (s + k[s[12:11]]));
            end else begin
                b = b - (mixb(a) ^ (s + k[s[12:11]]));
                s = s - DLT;
                a = a - (mixb(b) ^ (s + k[s[1:0]]));
            end
        end
        return {a, b};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
        w_edge = cyc + 1;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        cs = 1'b1; rd = 1'b1; addr = AW'(a);
        #1;
        d = rdata;
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_edge(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic load_all();
        for (int k = 0; k < 4; k++) bus_write(2 + k, key[k]);
        for (int i = 0; i < NREP; i++) begin
            bus_write(6 + 4*i, blk0[i]);
            bus_write(7 + 4*i, blk1[i]);
        end
    endtask

    task automatic run_and_check(input bit dec, input bit restart);
        logic [31:0] d;
        int start_edge;
        for (int i = 0; i < NREP; i++) expv[i] = ref_run(key, blk0[i], blk1[i], dec);
        bus_write(0, {30'b0, dec, 1'b1});
        start_edge = w_edge;
        peek(1, d);
        check("R5 busy after start", d, 32'h1);
        peek(0, d);
        check("R4 control start reads 0", d, {30'b0, dec, 1'b0});
        if (restart) begin
            wait_edge(start_edge + 40);
            bus_write(0, {30'b0, ~dec, 1'b1});
            peek(0, d);
            check("R9 mode unchanged by write while busy", d, {30'b0, dec, 1'b0});
        end
        wait_edge(start_edge + 130);
        peek(1, d);
        check("R5 still busy at edge 130", d, 32'h1);
        wait_edge(start_edge + 131);
        peek(1, d);
        check("R5 all-done at edge 131", d, 32'h2);
        for (int i = 0; i < NREP; i++) begin
            bus_read(8 + 4*i, d);
            check(dec ? "R7 result half0" : "R6 result half0", d, expv[i][63:32]);
            bus_read(9 + 4*i, d);
            check(dec ? "R7 result half1" : "R6 result half1", d, expv[i][31:0]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_fails++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        bus_read(0, d);  check("R1 control reset", d, 32'h0);
        bus_read(1, d);  check("R1 status reset", d, 32'h0);
        bus_read(3, d);  check("R1 key reset", d, 32'h0);
        bus_read(6, d);  check("R1 input reset", d, 32'h0);
        bus_read(9 + 4*(NREP-1), d); check("R1 result reset", d, 32'h0);

        // R2: write and read back
        for (int k = 0; k < 4; k++) begin
            v = $urandom;
            bus_write(2 + k, v);
            bus_read(2 + k, d);
            check("R2 key readback", d, v);
        end
        for (int i = 0; i < NREP; i++) begin
            v = $urandom;
            bus_write(7 + 4*i, v);
            bus_read(7 + 4*i, d);
            check("R2 input readback", d, v);
        end

        // R3: ignored writes and unmapped reads
        bus_write(1, 32'hFFFF_FFFF);
        bus_read(1, d);  check("R3 status write ignored", d, 32'h0);
        bus_write(8, 32'hDEAD_BEEF);
        bus_read(8, d);  check("R3 result write ignored", d, 32'h0);
        bus_read(6 + 4*NREP, d); check("R3 unmapped just past map", d, 32'h0);
        bus_read(255, d); check("R3 unmapped top", d, 32'h0);

        // R6/R7 directed: all-zero key and blocks, then round trip
        key = '0;
        for (int i = 0; i < NREP; i++) begin blk0[i] = '0; blk1[i] = '0; end
        load_all();
        run_and_check(1'b0, 1'b0);
        for (int i = 0; i < NREP; i++) begin blk0[i] = expv[i][63:32]; blk1[i] = expv[i][31:0]; end
        load_all();
        run_and_check(1'b1, 1'b0);
        bus_read(8, d); check("R7 round trip to zero", d, 32'h0);

        // R6/R7/R8 random: distinct blocks per replica, random mode
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 4; k++) key[k] = $urandom;
            for (int i = 0; i < NREP; i++) begin blk0[i] = $urandom; blk1[i] = $urandom; end
            blk0[NREP-1] = 32'hFFFF_FFFF;
            load_all();
            run_and_check(bit'($urandom & 1), 1'b0);
            if (NREP > 1) check("R8 replicas differ", 32'(expv[0] != expv[1]), 32'h1);
        end

        // R9: control write while busy ignored
        for (int i = 0; i < NREP; i++) begin blk0[i] = $urandom; blk1[i] = $urandom; end
        load_all();
        run_and_check(1'b0, 1'b1);

        // R10: results hold after rewriting key and inputs
        for (int k = 0; k < 4; k++) bus_write(2 + k, $urandom);
        for (int i = 0; i < NREP; i++) bus_write(6 + 4*i, $urandom);
        for (int i = 0; i < NREP; i++) begin
            bus_read(8 + 4*i, d);
            check("R10 result held", d, expv[i][63:32]);
        end
        bus_read(1, d); check("R10 status held all-done", d, 32'h2);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule